// File: doc/BRIEF.md
# Filter Gate Keeper

This block decides, for each implemented filter unit, whether new commands may enter that filter. Software writes a single control word. Bit n of that word asks for filter n's gate to be open (1) or closed (0). Reading the word returns those request bits together with the gate state that is really in force, which sits at bit n+16. A closed gate stalls new commands on that filter's command channel. It does not reject them.

Each filter keeps a count of the transactions it has accepted whose responses have not yet returned. An open request takes effect on the cycle after the request bit is stored. A close request first stalls new commands. The gate then shuts one cycle after the outstanding count has reached zero. If the request bit is written back to the current gate state before a pending change takes effect, the change is dropped and the reported state never moves. After reset every implemented gate is open. Bit positions for filters that are not implemented read as zero, and writes to them have no effect.

Top module: `filter_gate_keeper`

## Requirements
- R1: After reset, for each implemented filter, the request bit and the status bit both read 1, no stall is asserted, and the outstanding count is zero.
- R2: In the control word, filter n's request bit is at bit n and its status bit is at bit n+16. A write stores bits [NUM_FILTERS-1:0] as the request bits, and the read value shows them one cycle later. A write ignores the status field.
- R3: Request and status bits at positions NUM_FILTERS and above always read 0. Writing 1 to those positions changes nothing.
- R4: When a filter's request bit is 1 and its gate is closed, the status bit becomes 1 on the next clock edge. While the gate is still closed, the stall stays asserted.
- R5: A gate whose request bit is 0 shuts on the first clock edge at which its outstanding count is already zero. Before that edge the status bit stays 1.
- R6: A filter's stall output is high whenever its gate is closed or a close is pending (request 0 while status is 1). A command presented while the stall is high is not accepted and does not change the count.
- R7: A command is accepted when its valid is high and its stall is low, and each accepted command adds one to the count. A completion event subtracts one. If both arrive in the same cycle, the count is unchanged. A completion that arrives while the count is zero is ignored.
- R8: If the request bit returns to the current gate state before a pending close takes effect, the close is dropped and the status bit does not change.
- R9: When the outstanding count reaches its maximum of 2**CNT_W-1, the filter stalls. The stall lifts once a completion lowers the count.
- R10: Each filter's gate, count and stall are independent of the other filters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Control word write strobe |
| cfg_wdata_i | input | 32 | Control word write data; request bits at [NUM_FILTERS-1:0] |
| cfg_rdata_o | output | 32 | Control word read data: requests at [n], gate status at [n+16] |
| cmd_valid_i | input | NUM_FILTERS | Per-filter new command valid |
| cmd_done_i | input | NUM_FILTERS | Per-filter transaction completion event |
| cmd_stall_o | output | NUM_FILTERS | Per-filter command stall |

## Verification
Once a write is registered, the request bits appear on the read port one edge after the strobe cycle, and a pending-close stall rises on that same edge. An open request, or a close whose count is already zero, shows up in the status field one edge later, two edges after the strobe. A close that is waiting for drain shuts two edges after the cycle that carries the last completion: one edge for the count to reach zero and one for the gate to close. The counter-limit stall rises on the edge that brings the count to 2**CNT_W-1. The driver enqueues each expectation with its due cycle, computed from these latencies. The monitor compares the read word and the stall vector at the falling edge of exactly that cycle, so it checks both the time a change must not happen before and the time it must happen by.

// File: rtl/gk_pkg.sv
package gk_pkg;
  localparam int unsigned GK_MAX_FILTERS = 4;
  localparam int unsigned GK_STATUS_LSB  = 16;
  localparam int unsigned GK_WORD_W      = 32;

  typedef enum logic {
    GATE_SHUT = 1'b0,
    GATE_OPEN = 1'b1
  } gate_e;
endpackage

// File: rtl/gk_txn_counter.sv
module gk_txn_counter #(
  parameter int unsigned CNT_W = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic issue_i,
  input  logic retire_i,
  output logic empty_o,
  output logic full_o
);
  localparam logic [CNT_W-1:0] CntMax  = '1;
  localparam logic [CNT_W-1:0] CntZero = '0;

  logic [CNT_W-1:0] cnt_q;
  logic             retire_ok;

  // completions with nothing outstanding are dropped
  assign retire_ok = retire_i && (cnt_q != CntZero);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= CntZero;
    end else begin
      unique case ({issue_i, retire_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign empty_o = (cnt_q == CntZero);
  assign full_o  = (cnt_q == CntMax);

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && issue_i)); // R9
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && retire_i && !issue_i) |=> empty_o); // R7
endmodule

// File: rtl/gk_gate_state.sv
module gk_gate_state
  import gk_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic want_open_i,
  input  logic drained_i,
  output logic open_o
);
  gate_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (want_open_i)    state_d = GATE_OPEN;
    else if (drained_i) state_d = GATE_SHUT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= GATE_OPEN;
    else         state_q <= state_d;
  end

  assign open_o = (state_q == GATE_OPEN);

  AST_OPEN_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (want_open_i && !open_o) |=> open_o); // R4
  AST_SHUT_AFTER_DRAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (open_o && !(drained_i && !want_open_i)) |=> open_o); // R5
  AST_HOLD_WHEN_MATCHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (want_open_i == open_o) |=> $stable(open_o)); // R8
endmodule

// File: rtl/gk_filter.sv
module gk_filter #(
  parameter int unsigned CNT_W = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic want_open_i,
  input  logic cmd_valid_i,
  input  logic cmd_done_i,
  output logic stall_o,
  output logic open_o
);
  logic empty, full, issue;

  // stall while shut, while a close is pending, or at the count limit
  assign stall_o = !(open_o && want_open_i) || full;
  assign issue   = cmd_valid_i && !stall_o;

  gk_txn_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .issue_i (issue),
    .retire_i(cmd_done_i),
    .empty_o (empty),
    .full_o  (full)
  );

  gk_gate_state i_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .want_open_i(want_open_i),
    .drained_i  (empty),
    .open_o     (open_o)
  );

  AST_STALL_WHEN_SHUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !open_o |-> stall_o); // R6
  AST_SHUT_ONLY_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (open_o && !empty) |=> open_o); // R5
endmodule

// File: rtl/filter_gate_keeper.sv
module filter_gate_keeper
  import gk_pkg::*;
#(
  parameter int unsigned NUM_FILTERS = 4,
  parameter int unsigned CNT_W       = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cfg_we_i,
  input  logic [31:0]            cfg_wdata_i,
  output logic [31:0]            cfg_rdata_o,
  input  logic [NUM_FILTERS-1:0] cmd_valid_i,
  input  logic [NUM_FILTERS-1:0] cmd_done_i,
  output logic [NUM_FILTERS-1:0] cmd_stall_o
);
  localparam int unsigned NumF = (NUM_FILTERS > GK_MAX_FILTERS) ? GK_MAX_FILTERS : NUM_FILTERS;

  logic [NUM_FILTERS-1:0] want_q;
  logic [NUM_FILTERS-1:0] open_w;
  logic                   unused_wdata;

  assign unused_wdata = ^cfg_wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       want_q <= '1;
    else if (cfg_we_i) want_q <= cfg_wdata_i[NUM_FILTERS-1:0];
  end

  for (genvar f = 0; f < NUM_FILTERS; f++) begin : g_filt
    gk_filter #(.CNT_W(CNT_W)) i_filt (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .want_open_i(want_q[f]),
      .cmd_valid_i(cmd_valid_i[f]),
      .cmd_done_i (cmd_done_i[f]),
      .stall_o    (cmd_stall_o[f]),
      .open_o     (open_w[f])
    );
  end

  always_comb begin
    cfg_rdata_o = '0;
    cfg_rdata_o[NumF-1:0]                = want_q[NumF-1:0];
    cfg_rdata_o[GK_STATUS_LSB +: NumF]   = open_w[NumF-1:0];
  end

  AST_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> (cfg_rdata_o[NumF-1:0] == $past(cfg_wdata_i[NumF-1:0]))); // R2
endmodule

// File: tb/test_filter_gate_keeper.sv
module test_filter_gate_keeper;
  localparam int NF = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          we = 1'b0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NF-1:0] cmd_valid = '0;
  logic [NF-1:0] cmd_done = '0;
  logic [NF-1:0] stall;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit finished = 1'b0;

  typedef struct {
    int          due;
    logic [31:0] rd;
    logic [NF-1:0] st;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  always #10 clk = ~clk; // 50 MHz

  filter_gate_keeper #(.NUM_FILTERS(NF), .CNT_W(4)) i_filter_gate_keeper (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .cfg_we_i   (we),
    .cfg_wdata_i(wdata),
    .cfg_rdata_o(rdata),
    .cmd_valid_i(cmd_valid),
    .cmd_done_i (cmd_done),
    .cmd_stall_o(stall)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare due expectations away from the active edge
  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].due == cyc) begin
      exp_t e;
      e = sb_q.pop_front();
      n_chk++;
      if (rdata !== e.rd || stall !== e.st) begin
        n_fail++;
        $display("FAIL %s: rdata=%h stall=%b expected rdata=%h stall=%b",
                 e.tag, rdata, stall, e.rd, e.st);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(int d, logic [NF-1:0] rq, logic [NF-1:0] op,
                            logic [NF-1:0] st, string tag);
    exp_t e;
    e.due = cyc + d;
    e.rd  = 32'h0;
    e.rd[NF-1:0] = rq;
    e.rd[16 +: NF] = op;
    e.st  = st;
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic write_req(logic [31:0] v);
    we = 1'b1;
    wdata = v;
    tick(1);
    we = 1'b0;
    wdata = '0;
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      report();
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;

    // R1 reset state
    expect_out(1, 3'b111, 3'b111, 3'b000, "R1 reset state");
    tick(1);

    // R3 absent and status bits ignored on write
    expect_out(1, 3'b111, 3'b111, 3'b000, "R3 upper bits ignored");
    write_req(32'hFFFF_FFFF);

    // close filter 1 with nothing outstanding
    expect_out(1, 3'b101, 3'b111, 3'b010, "R6 pending close stalls");
    expect_out(2, 3'b101, 3'b101, 3'b010, "R5 close with empty count");
    write_req(32'h5);
    tick(1);

    expect_out(1, 3'b111, 3'b101, 3'b010, "R4 open pending");
    expect_out(2, 3'b111, 3'b111, 3'b000, "R4 open after one cycle");
    write_req(32'h7);
    tick(1);

    // filter 0: three outstanding, then close
    expect_out(1, 3'b111, 3'b111, 3'b000, "R7 commands accepted");
    cmd_valid = 3'b001;
    tick(3);
    cmd_valid = '0;
    expect_out(1, 3'b110, 3'b111, 3'b001, "R6 stall while draining");
    expect_out(3, 3'b110, 3'b111, 3'b001, "R5 waits for drain");
    write_req(32'h6);
    cmd_valid = 3'b001; // must not be accepted
    tick(2);
    cmd_valid = '0;
    cmd_done = 3'b001;
    expect_out(2, 3'b110, 3'b111, 3'b001, "R6 R5 one still outstanding");
    tick(2);
    cmd_done = '0;
    tick(1);
    cmd_done = 3'b001;
    expect_out(1, 3'b110, 3'b111, 3'b001, "R5 count just emptied");
    expect_out(2, 3'b110, 3'b110, 3'b001, "R5 closes after last completion");
    tick(1);
    cmd_done = '0;
    tick(1);

    expect_out(1, 3'b111, 3'b110, 3'b001, "R4 reopen pending");
    expect_out(2, 3'b111, 3'b111, 3'b000, "R4 reopened");
    write_req(32'h7);
    tick(1);

    // cancel a pending close on filter 2
    cmd_valid = 3'b100;
    tick(1);
    cmd_valid = '0;
    expect_out(1, 3'b011, 3'b111, 3'b100, "R6 close pending on filter 2");
    write_req(32'h3);
    expect_out(1, 3'b111, 3'b111, 3'b000, "R8 cancelled close keeps gate open");
    expect_out(3, 3'b111, 3'b111, 3'b000, "R8 status never moved");
    write_req(32'h7);
    tick(2);
    cmd_done = 3'b100;
    tick(1);
    cmd_done = '0;

    // ignored completions and paired events on filter 1
    cmd_done = 3'b010;
    tick(2);
    cmd_done = '0;
    cmd_valid = 3'b010;
    tick(1);
    cmd_done = 3'b010;
    tick(1);
    cmd_valid = '0;
    cmd_done = '0;
    expect_out(1, 3'b101, 3'b111, 3'b010, "R7 close pending");
    expect_out(3, 3'b101, 3'b111, 3'b010, "R7 count survives ignored and paired events");
    write_req(32'h5);
    tick(2);
    cmd_done = 3'b010;
    expect_out(1, 3'b101, 3'b111, 3'b010, "R7 last completion");
    expect_out(2, 3'b101, 3'b101, 3'b010, "R7 single outstanding drained");
    tick(1);
    cmd_done = '0;
    tick(1);
    expect_out(2, 3'b111, 3'b111, 3'b000, "R4 filter 1 reopened");
    write_req(32'h7);
    tick(1);

    // counter limit on filter 0
    cmd_valid = 3'b001;
    expect_out(14, 3'b111, 3'b111, 3'b000, "R9 below limit");
    expect_out(15, 3'b111, 3'b111, 3'b001, "R9 stall at limit");
    expect_out(17, 3'b111, 3'b111, 3'b001, "R9 stall holds at limit");
    tick(17);
    cmd_valid = '0;
    cmd_done = 3'b001;
    expect_out(1, 3'b111, 3'b111, 3'b000, "R9 stall released");
    tick(15);
    cmd_done = '0;
    expect_out(2, 3'b110, 3'b110, 3'b001, "R9 counter back to zero");
    write_req(32'h6);
    tick(1);
    expect_out(2, 3'b111, 3'b111, 3'b000, "R4 filter 0 reopened");
    write_req(32'h7);
    tick(1);

    // independence
    cmd_valid = 3'b001;
    expect_out(1, 3'b011, 3'b111, 3'b100, "R10 only filter 2 stalls");
    expect_out(2, 3'b011, 3'b011, 3'b100, "R10 filter 0 unaffected");
    write_req(32'h3);
    tick(1);
    cmd_valid = '0;
    cmd_done = 3'b001;
    tick(2);
    cmd_done = '0;

    // field layout patterns
    expect_out(2, 3'b000, 3'b000, 3'b111, "R2 all closed");
    write_req(32'h0);
    tick(1);
    expect_out(2, 3'b010, 3'b010, 3'b101, "R2 single open");
    write_req(32'h2);
    tick(1);
    expect_out(2, 3'b111, 3'b111, 3'b000, "R3 absent request bit ignored");
    write_req(32'h0000_000F);
    tick(4);

    if (sb_q.size() != 0) begin
      n_chk++;
      n_fail++;
      $display("FAIL scoreboard: pending=%0d expected=0", sb_q.size());
    end
    finished = 1'b1;
    report();
    $finish;
  end
endmodule